// File: doc/BRIEF.md
# Write-once byte memory with mode decoder

This block models a one-time-writable byte memory. After reset or an erase every bit holds 1, and a write can only clear bits. Three active-low controls select the mode: chip select, output gate and write strobe. Two flags stand in for raised voltages. `vpp_hi` marks the programming supply as raised, and `a9_hv` marks the raised level on address line 9. From these inputs the block decodes the following modes:

- normal read
- output disabled
- standby
- program
- program check (verify)
- program inhibit
- identifier read

The data bus is split into `din` and `q`. `q_en` marks when the block would drive the shared bus, which replaces a tri-state pin.

Access, output-gate and release delays are counted in clock cycles. `q_valid` shows when the output byte may be sampled. An address change drops `q_valid` in the same cycle and restarts the access count. The array depth is `2**ADDR_W`: ADDR_W = 13 gives the 8K x 8 organisation, and the default elaboration uses 11.

Top module: `eprom_core`

## Requirements
- R1: On reset, and on any clock edge with `erase_all` high, every byte becomes all ones (0xFF when DATA_W = 8).
- R2: A write happens on each clock edge where `vpp_hi`=1, `ce_n`=0 and `pgm_n`=0. The addressed byte becomes its old value AND `din`.
- R3: With `vpp_hi`=0 a low `pgm_n` has no effect, and the array is unchanged.
- R4: Normal read: with `vpp_hi`=0, `a9_hv`=0, `ce_n`=0 and `oe_n`=0, the addressed byte is driven (`q_en`=1). Once `q_valid`=1, `q` equals that byte.
- R5: Standby: with `ce_n`=1 and `vpp_hi`=0, `q_en` is 0 after at most REL_CYC edges, whatever `oe_n` does.
- R6: Program inhibit: with `vpp_hi`=1 and `ce_n`=1, no write happens and `q_en` goes to 0 after at most REL_CYC edges.
- R7: Verify: with `vpp_hi`=1, `ce_n`=0, `oe_n`=0 and `pgm_n`=1, the addressed byte is driven on `q`.
- R8: Identifier read: with `a9_hv`=1 during a read (`vpp_hi`=0), address bit 0 = 0 returns 0x20 and address bit 0 = 1 returns 0x08.
- R9: If `ce_n` falls with the address held, `q_valid` rises at the ACC_CYC-th rising edge that sees `ce_n` low, provided the output gate has been low long enough.
- R10: If `oe_n` falls with the chip long selected, `q_valid` rises at the OE_CYC-th rising edge that sees `oe_n` low.
- R11: A change of `addr` drops `q_valid` in the same cycle, before any clock edge. The access count then restarts from zero.
- R12: When the drive condition ends, `q_valid` drops at once. `q_en` stays high for REL_CYC rising edges, holding the last valid byte, and then goes to 0.
- R13: Output disabled: with `ce_n`=0 and `oe_n`=1, `q_en` is 0 after the release delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; fills the array with ones |
| erase_all | input | 1 | Synchronous erase of the whole array |
| ce_n | input | 1 | Active-low chip select |
| oe_n | input | 1 | Active-low output gate |
| pgm_n | input | 1 | Active-low write strobe |
| vpp_hi | input | 1 | Programming supply raised |
| a9_hv | input | 1 | Raised level on address line 9 (identifier read) |
| addr | input | ADDR_W | Byte address |
| din | input | DATA_W | Byte to program |
| q | output | DATA_W | Output byte (zero while not driven) |
| q_en | output | 1 | Bus drive enable |
| q_valid | output | 1 | Output byte is valid |

## Verification
A reference model in the bench predicts `q`, `q_en` and `q_valid` on every cycle. It is driven with both directed patterns and long random sequences.

- The directed patterns cover a double write to one byte, which separates AND-merge from overwrite. They include a write strobe with the supply flag clear and a strobe while deselected, which separate the ignored strobes from real writes.
- Reading back under verify and under identifier read with either value of address bit 0 separates the three read paths.
- Timed edges of chip select, of the output gate and of the address separate the access, output-gate and release counts from one another.
- The random phase holds random mode combinations over a small address range for random spans, so writes, erases and reads collide on the same bytes.

// File: rtl/eprom_core.sv
module eprom_core #(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 8,
  parameter int ACC_CYC = 6,
  parameter int OE_CYC = 2,
  parameter int REL_CYC = 2,
  parameter logic [DATA_W-1:0] MFR_CODE = 8'h20,
  parameter logic [DATA_W-1:0] DEV_CODE = 8'h08
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              erase_all,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              pgm_n,
  input  logic              vpp_hi,
  input  logic              a9_hv,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] q,
  output logic              q_en,
  output logic              q_valid
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int MAX_AO = (ACC_CYC > OE_CYC) ? ACC_CYC : OE_CYC;
  localparam int MAXC = (MAX_AO > REL_CYC) ? MAX_AO : REL_CYC;
  localparam int CW = $clog2(MAXC + 1) + 1;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [ADDR_W-1:0] addr_q;
  logic [CW-1:0]     acc_cnt, oe_cnt, rel_cnt;
  logic [DATA_W-1:0] q_hold;
  logic              wr, drv, addr_same;
  logic [DATA_W-1:0] cur;

  assign wr        = vpp_hi & ~ce_n & ~pgm_n;
  assign drv       = ~ce_n & ~oe_n & (~vpp_hi | pgm_n);
  assign addr_same = (addr == addr_q);
  assign cur       = (a9_hv & ~vpp_hi) ? (addr[0] ? DEV_CODE : MFR_CODE) : mem[addr];
  assign q_valid   = drv & addr_same & (acc_cnt == CW'(ACC_CYC)) & (oe_cnt == CW'(OE_CYC));
  assign q_en      = drv | (rel_cnt != '0);
  assign q         = !q_en ? '0 : (q_valid ? cur : q_hold);

  always_ff @(posedge clk) begin
    if (!rst_n || erase_all) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '1;
    end else if (wr) begin
      mem[addr] <= mem[addr] & din;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      acc_cnt <= '0;
      oe_cnt  <= '0;
      rel_cnt <= '0;
      q_hold  <= '0;
    end else begin
      addr_q <= addr;
      if (ce_n || !addr_same) acc_cnt <= '0;
      else if (acc_cnt != CW'(ACC_CYC)) acc_cnt <= acc_cnt + 1'b1;
      if (oe_n) oe_cnt <= '0;
      else if (oe_cnt != CW'(OE_CYC)) oe_cnt <= oe_cnt + 1'b1;
      if (drv) rel_cnt <= CW'(REL_CYC);
      else if (rel_cnt != '0) rel_cnt <= rel_cnt - 1'b1;
      if (q_valid) q_hold <= cur;
    end
  end
endmodule

// File: rtl/eprom_core_chk.sv
module eprom_core_chk #(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 8,
  parameter int REL_CYC = 2,
  parameter logic [DATA_W-1:0] MFR_CODE = 8'h20,
  parameter logic [DATA_W-1:0] DEV_CODE = 8'h08
) (
  input logic              clk,
  input logic              rst_n,
  input logic              erase_all,
  input logic              ce_n,
  input logic              oe_n,
  input logic              vpp_hi,
  input logic              a9_hv,
  input logic [ADDR_W-1:0] addr,
  input logic [DATA_W-1:0] q,
  input logic              q_en,
  input logic              q_valid
);
  localparam int HW = $clog2(REL_CYC + 1) + 1;
  logic [HW-1:0] hi_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hi_cnt <= '0;
    else if (!ce_n) hi_cnt <= '0;
    else if (hi_cnt != HW'(REL_CYC)) hi_cnt <= hi_cnt + 1'b1;
  end

  AST_DESELECT_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (ce_n && hi_cnt == HW'(REL_CYC)) |-> !q_en); // R5

  AST_VALID_NEEDS_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
    q_valid |-> (!ce_n && !oe_n && q_en)); // R4

  AST_READ_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (q_valid && $past(q_valid) && $stable(addr) && $stable(a9_hv) && $stable(vpp_hi)
     && !$past(erase_all)) |-> $stable(q)); // R3

  AST_SIG_MFR: assert property (@(posedge clk) disable iff (!rst_n)
    (q_valid && a9_hv && !vpp_hi && !addr[0]) |-> (q == MFR_CODE)); // R8

  AST_SIG_DEV: assert property (@(posedge clk) disable iff (!rst_n)
    (q_valid && a9_hv && !vpp_hi && addr[0]) |-> (q == DEV_CODE)); // R8
endmodule

bind eprom_core eprom_core_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .REL_CYC(REL_CYC),
  .MFR_CODE(MFR_CODE), .DEV_CODE(DEV_CODE)
) u_chk (
  .clk(clk), .rst_n(rst_n), .erase_all(erase_all), .ce_n(ce_n), .oe_n(oe_n),
  .vpp_hi(vpp_hi), .a9_hv(a9_hv), .addr(addr), .q(q), .q_en(q_en), .q_valid(q_valid)
);

// File: tb/eprom_core_bench.sv
`timescale 1ns/1ps
module eprom_core_bench;
  localparam int AW = 11;
  localparam int ACC = 6;
  localparam int OEC = 2;
  localparam int REL = 2;

  logic clk = 0, rst_n = 0, erase_all = 0;
  logic ce_n = 1, oe_n = 1, pgm_n = 1, vpp_hi = 0, a9_hv = 0;
  logic [AW-1:0] addr = '0;
  logic [7:0] din = '0;
  logic [7:0] q;
  logic q_en, q_valid;

  int checks = 0, errors = 0;
  bit done = 0;
  string cur_req = "R1";

  eprom_core #(.ADDR_W(AW), .DATA_W(8), .ACC_CYC(ACC), .OE_CYC(OEC), .REL_CYC(REL))
    u_eprom_core (.clk(clk), .rst_n(rst_n), .erase_all(erase_all), .ce_n(ce_n), .oe_n(oe_n),
                  .pgm_n(pgm_n), .vpp_hi(vpp_hi), .a9_hv(a9_hv), .addr(addr), .din(din),
                  .q(q), .q_en(q_en), .q_valid(q_valid));

  always #2 clk = ~clk;

  logic [7:0] m_mem [1 << AW];
  int m_acc = 0, m_oe = 0, m_rel = 0;
  logic [AW-1:0] m_prev = '0;
  logic [7:0] m_hold = '0;

  function automatic bit m_drv();
    return !ce_n && !oe_n && (!vpp_hi || pgm_n);
  endfunction
  function automatic bit m_valid();
    return m_drv() && addr == m_prev && m_acc == ACC && m_oe == OEC;
  endfunction
  function automatic logic [7:0] m_data();
    if (a9_hv && !vpp_hi) return addr[0] ? 8'h08 : 8'h20;
    return m_mem[addr];
  endfunction

  task automatic check(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < (1 << AW); i++) m_mem[i] = 8'hFF;
      m_acc = 0; m_oe = 0; m_rel = 0; m_prev = '0; m_hold = '0;
    end else begin
      bit v, d;
      logic [7:0] dat;
      v = m_valid(); d = m_drv(); dat = m_data();
      if (v) m_hold = dat;
      if (erase_all) begin
        for (int i = 0; i < (1 << AW); i++) m_mem[i] = 8'hFF;
      end else if (vpp_hi && !ce_n && !pgm_n) m_mem[addr] = m_mem[addr] & din;
      m_acc = (ce_n || addr != m_prev) ? 0 : (m_acc < ACC ? m_acc + 1 : ACC);
      m_oe  = oe_n ? 0 : (m_oe < OEC ? m_oe + 1 : OEC);
      m_rel = d ? REL : (m_rel > 0 ? m_rel - 1 : 0);
      m_prev = addr;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      bit en, v;
      logic [7:0] eq;
      en = m_drv() || m_rel > 0;
      v = m_valid();
      eq = !en ? 8'h00 : (v ? m_data() : m_hold);
      check(cur_req, "model q_en", q_en, en);
      check(cur_req, "model q_valid", q_valid, v);
      check(cur_req, "model q", q, eq);
    end
  end

  task automatic drive(bit c, bit o, bit p, bit v, bit h, int a, int d);
    @(posedge clk); #1;
    ce_n = c; oe_n = o; pgm_n = p; vpp_hi = v; a9_hv = h;
    addr = AW'(a); din = 8'(d);
  endtask
  task automatic edges(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask
  task automatic expect_read(string req, int exp);
    @(negedge clk);
    check(req, "q_valid", q_valid, 1);
    check(req, "q", q, exp);
  endtask
  task automatic read_at(int a, bit v, bit h);
    drive(1, 1, 1, v, h, a, 0);
    edges(REL + 1);
    drive(0, 0, 1, v, h, a, 0);
    edges(ACC + 1);
  endtask

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      done = 1; errors++; checks++;
      $display("FAIL watchdog expired");
      summary();
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    @(negedge clk);
    check("R1", "q_en in reset", q_en, 0);
    rst_n = 1;

    cur_req = "R1";
    read_at(5, 0, 0);
    expect_read("R1", 8'hFF);

    cur_req = "R2";
    drive(0, 1, 0, 1, 0, 5, 8'hA5);
    drive(0, 1, 1, 1, 0, 5, 0);
    drive(0, 1, 0, 1, 0, 5, 8'h3C);
    drive(0, 1, 1, 1, 0, 5, 0);
    read_at(5, 0, 0);
    expect_read("R2", 8'h24);

    cur_req = "R3";
    drive(0, 1, 0, 0, 0, 6, 8'h00);
    edges(3);
    read_at(6, 0, 0);
    expect_read("R3", 8'hFF);

    cur_req = "R6";
    drive(1, 0, 0, 1, 0, 7, 8'h00);
    edges(REL + 1);
    @(negedge clk);
    check("R6", "q_en during inhibit", q_en, 0);
    read_at(7, 0, 0);
    expect_read("R6", 8'hFF);

    cur_req = "R7";
    read_at(5, 1, 0);
    expect_read("R7", 8'h24);

    cur_req = "R8";
    read_at(0, 0, 1);
    expect_read("R8", 8'h20);
    read_at(1, 0, 1);
    expect_read("R8", 8'h08);

    cur_req = "R9";
    drive(1, 0, 1, 0, 0, 5, 0);
    edges(REL + 2);
    drive(0, 0, 1, 0, 0, 5, 0);
    edges(ACC - 1);
    @(negedge clk);
    check("R9", "q_valid one edge early", q_valid, 0);
    @(negedge clk);
    check("R9", "q_valid at access count", q_valid, 1);

    cur_req = "R12";
    drive(0, 1, 1, 0, 0, 5, 0);
    @(negedge clk);
    check("R12", "q_valid drops", q_valid, 0);
    check("R12", "q_en held", q_en, 1);
    check("R12", "held byte", q, 8'h24);
    edges(REL - 1);
    @(negedge clk);
    check("R12", "q_en before release end", q_en, 1);
    @(negedge clk);
    check("R13", "q_en off, gate high", q_en, 0);

    cur_req = "R10";
    drive(0, 0, 1, 0, 0, 5, 0);
    edges(OEC - 1);
    @(negedge clk);
    check("R10", "q_valid one edge early", q_valid, 0);
    @(negedge clk);
    check("R10", "q_valid at gate count", q_valid, 1);

    cur_req = "R11";
    drive(0, 0, 1, 0, 0, 6, 0);
    @(negedge clk);
    check("R11", "q_valid drops on address change", q_valid, 0);
    edges(ACC + 1);
    expect_read("R11", 8'hFF);

    cur_req = "R5";
    drive(1, 0, 1, 0, 0, 6, 0);
    edges(REL);
    @(negedge clk);
    check("R5", "q_en in standby", q_en, 0);

    cur_req = "R1";
    drive(1, 1, 1, 0, 0, 5, 0);
    erase_all = 1;
    edges(1);
    erase_all = 0;
    read_at(5, 0, 0);
    expect_read("R1", 8'hFF);

    cur_req = "R4";
    for (int k = 0; k < 600; k++) begin
      int span;
      bit c, o, p, v, h;
      c = ($urandom % 4) == 0; o = ($urandom % 3) == 0; p = ($urandom % 3) != 0;
      v = ($urandom % 3) == 0; h = ($urandom % 5) == 0;
      drive(c, o, p, v, h, $urandom % 8, $urandom % 256);
      erase_all = ($urandom % 60) == 0;
      span = 1 + $urandom % 10;
      edges(1);
      erase_all = 0;
      if (span > 1) edges(span - 1);
    end

    done = 1;
    summary();
  end
endmodule